// File: doc/BRIEF.md
# Stereo Sample Delay Line

This block holds back a stereo stream of audio samples by a programmable number of sample periods, with an independent delay for the left and the right channel. Each accepted sample (a clock cycle with the valid strobe high) is written into a per-channel circular buffer. The output for that cycle is read back from the slot written a programmed number of samples earlier. Idle cycles between samples do not count toward the delay.

Each delay is 13 bits wide and arrives split across a 5-bit high field and an 8-bit low field. A control byte carries two per-channel mute bits and a two-bit mode field; the all-ones mode code selects a bypass that ignores both delays. A muted channel drives zeros but keeps filling its buffer, so the delayed stream is intact when the mute is released. The buffer depth is a parameter. Delays are exact for values below that depth.

Top module: `sdl_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` is 0 and both output samples are 0.
- R2: `out_valid` is high exactly one clock cycle after each cycle in which `in_valid` is high, and low otherwise, whatever the delay, mute and mode settings.
- R3: A channel's delay in samples is the unsigned value {hi[4:0], lo[7:0]}: the high field supplies bits 12:8 and the low field supplies bits 7:0.
- R4: With a delay of 0, the output sample one cycle after a valid input is that same input sample.
- R5: With a delay d in the range 1 to DEPTH-1, the output after a valid input is the sample accepted d valid samples earlier on that channel; cycles with `in_valid` low are not counted.
- R6: Control bit 7 set forces the right output sample to 0, and control bit 6 set forces the left output sample to 0. Each bit affects only its own channel.
- R7: A muted channel keeps writing its buffer, so the first output after unmuting already carries the correctly delayed sample.
- R8: Control bits 1:0 equal to 2'b11 select bypass: both outputs carry the current input samples, whatever the delays. The codes 00, 01 and 10 behave identically and apply the delays. Mute still applies in bypass.
- R9: A new delay value is applied from the next valid sample on. Changing the delay does not clear the buffer.
- R10: The left and right delays are independent: each channel's output depends only on its own delay and its own input history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe: a stereo sample is present this cycle |
| in_left | input | SAMPLE_W | Left input sample |
| in_right | input | SAMPLE_W | Right input sample |
| left_dly_hi | input | 5 | Left delay, bits 12:8 |
| left_dly_lo | input | 8 | Left delay, bits 7:0 |
| right_dly_hi | input | 5 | Right delay, bits 12:8 |
| right_dly_lo | input | 8 | Right delay, bits 7:0 |
| ctrl_byte | input | 8 | Bit 7 mutes right, bit 6 mutes left, bits 1:0 = 11 selects bypass |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_left | output | SAMPLE_W | Delayed left sample |
| out_right | output | SAMPLE_W | Delayed right sample |

## Verification
Every result falls due exactly one clock edge after the valid input that produced it, and the delay setting does not change this. The bench therefore drives a sample on a falling edge, lowers the strobe on the next falling edge, and checks `out_valid` and both samples at that point. It checks `out_valid` low on the falling edge of each idle cycle that follows. The expected delayed samples come from a bench-side history indexed by the count of accepted samples. That count is exactly what R5 says the delay is measured in, so randomly inserted idle gaps do not shift the expected values. Delayed outputs that reach back before the first accepted sample are not compared; mute, bypass and zero-delay outputs are always compared.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int DLY_W    = 13;
    localparam int DLY_HI_W = 5;
    localparam int DLY_LO_W = 8;
    localparam int CTRL_W   = 8;

    localparam int MUTE_R_BIT = 7;
    localparam int MUTE_L_BIT = 6;

    typedef enum logic [1:0] {
        MODE_FMT_A = 2'b00,
        MODE_FMT_B = 2'b01,
        MODE_FMT_C = 2'b10,
        MODE_THRU  = 2'b11
    } path_mode_e;

    typedef struct packed {
        logic       mute_r;
        logic       mute_l;
        path_mode_e mode;
    } path_ctl_t;

    typedef logic [DLY_W-1:0] delay_t;

    function automatic delay_t join_delay(input logic [DLY_HI_W-1:0] hi,
                                          input logic [DLY_LO_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/sdl_ctl_decode.sv
module sdl_ctl_decode
    import sdl_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_byte,
    output path_ctl_t         ctl,
    output logic              bypass
);

    logic [3:0] unused_fmt_bits;
    assign unused_fmt_bits = ctrl_byte[5:2];

    always_comb begin
        ctl.mute_r = ctrl_byte[MUTE_R_BIT];
        ctl.mute_l = ctrl_byte[MUTE_L_BIT];
        ctl.mode   = path_mode_e'(ctrl_byte[1:0]);
        bypass     = (ctl.mode == MODE_THRU);
    end

endmodule

// File: rtl/sdl_chan.sv
module sdl_chan
    import sdl_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  delay_t              delay,
    input  logic                bypass,
    input  logic                mute,
    output logic [SAMPLE_W-1:0] out_sample
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [SAMPLE_W-1:0] ring_q [DEPTH];
    logic [ADDR_W-1:0]   wr_ptr_q;
    logic [ADDR_W-1:0]   dly_addr;
    logic [ADDR_W-1:0]   rd_addr;
    logic                direct;
    logic [SAMPLE_W-1:0] picked;

    always_comb begin
        dly_addr = ADDR_W'(delay);
        rd_addr  = wr_ptr_q - dly_addr;
        direct   = bypass || (delay == '0);
        picked   = direct ? in_sample : ring_q[rd_addr];
    end

    // buffer is written even while muted so the stream survives a mute
    always_ff @(posedge clk) begin
        if (in_valid) begin
            ring_q[wr_ptr_q] <= in_sample;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q   <= '0;
            out_sample <= '0;
        end else if (in_valid) begin
            wr_ptr_q   <= wr_ptr_q + 1'b1;
            out_sample <= mute ? '0 : picked;
        end
    end

    // R5: pointer steps once per accepted sample
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> wr_ptr_q == ADDR_W'($past(wr_ptr_q) + 1'b1));

    // R5: idle cycles leave the pointer alone
    p_ptr_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(wr_ptr_q));

    // R6: a muted sample leaves the channel as zero
    p_mute_zero_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && mute |=> out_sample == '0);

    // R8: bypass without mute forwards the current input
    p_thru_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && bypass && !mute |=> out_sample == $past(in_sample));

endmodule

// File: rtl/sdl_top.sv
module sdl_top
    import sdl_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ADDR_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_left,
    input  logic [SAMPLE_W-1:0]  in_right,
    input  logic [DLY_HI_W-1:0]  left_dly_hi,
    input  logic [DLY_LO_W-1:0]  left_dly_lo,
    input  logic [DLY_HI_W-1:0]  right_dly_hi,
    input  logic [DLY_LO_W-1:0]  right_dly_lo,
    input  logic [CTRL_W-1:0]    ctrl_byte,
    output logic                 out_valid,
    output logic [SAMPLE_W-1:0]  out_left,
    output logic [SAMPLE_W-1:0]  out_right
);

    localparam int NCH = 2;
    localparam int CH_L = 0;
    localparam int CH_R = 1;

    path_ctl_t ctl;
    logic      bypass;

    logic [SAMPLE_W-1:0] ch_in   [NCH];
    logic [SAMPLE_W-1:0] ch_out  [NCH];
    delay_t              ch_dly  [NCH];
    logic                ch_mute [NCH];

    sdl_ctl_decode u_dec (
        .ctrl_byte (ctrl_byte),
        .ctl       (ctl),
        .bypass    (bypass)
    );

    always_comb begin
        ch_in[CH_L]   = in_left;
        ch_in[CH_R]   = in_right;
        ch_dly[CH_L]  = join_delay(left_dly_hi, left_dly_lo);
        ch_dly[CH_R]  = join_delay(right_dly_hi, right_dly_lo);
        ch_mute[CH_L] = ctl.mute_l;
        ch_mute[CH_R] = ctl.mute_r;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sdl_chan #(
            .SAMPLE_W (SAMPLE_W),
            .ADDR_W   (ADDR_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (in_valid),
            .in_sample  (ch_in[c]),
            .delay      (ch_dly[c]),
            .bypass     (bypass),
            .mute       (ch_mute[c]),
            .out_sample (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    assign out_left  = ch_out[CH_L];
    assign out_right = ch_out[CH_R];

    // R2: strobe follows input by exactly one cycle
    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: zero delay on the left is a pass-through
    p_pass_left_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && !ctrl_byte[MUTE_L_BIT] && left_dly_hi == '0 && left_dly_lo == '0
        |=> out_left == $past(in_left));

    // R6: right mute bit clears only the right output
    p_mute_right_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && ctrl_byte[MUTE_R_BIT] |=> out_right == '0);

    // R1: quiet first cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        rst |=> !out_valid && out_left == '0 && out_right == '0);

endmodule

// File: tb/sdl_top_tb.sv
module sdl_top_tb;

    localparam int SW = 16;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;
    localparam int HIST = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_left = '0;
    logic [SW-1:0] in_right = '0;
    logic [4:0]    dly_hi [2];
    logic [7:0]    dly_lo [2];
    logic [7:0]    ctrl_byte = 8'h00;
    logic          out_valid;
    logic [SW-1:0] out_left;
    logic [SW-1:0] out_right;

    int n_vec = 0;
    int n_bad = 0;
    int n_acc = 0;
    logic [SW-1:0] hist [2][HIST];

    always #10 clk = ~clk;

    sdl_top #(.SAMPLE_W(SW), .ADDR_W(AW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_left      (in_left),
        .in_right     (in_right),
        .left_dly_hi  (dly_hi[0]),
        .left_dly_lo  (dly_lo[0]),
        .right_dly_hi (dly_hi[1]),
        .right_dly_lo (dly_lo[1]),
        .ctrl_byte    (ctrl_byte),
        .out_valid    (out_valid),
        .out_left     (out_left),
        .out_right    (out_right)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int delay_of(input int c);
        return int'({dly_hi[c], dly_lo[c]});   // R3: hi is bits 12:8
    endfunction

    // returns 1 when the expected value is known
    function automatic bit expect_ch(input int c, input logic [SW-1:0] cur,
                                     output logic [SW-1:0] e);
        int d;
        bit muted;
        d = delay_of(c);
        muted = (c == 0) ? ctrl_byte[6] : ctrl_byte[7];
        if (muted) begin e = '0; return 1; end
        if (ctrl_byte[1:0] == 2'b11 || d == 0) begin e = cur; return 1; end
        if (n_acc < d) begin e = '0; return 0; end
        e = hist[c][(n_acc - d) % HIST];
        return 1;
    endfunction

    task automatic set_dly(input int c, input int d);
        dly_hi[c] = 5'(d >> 8);
        dly_lo[c] = 8'(d);
    endtask

    task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r, input string req);
        logic [SW-1:0] el, er;
        bit kl, kr;
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        kl = expect_ch(0, l, el);
        kr = expect_ch(1, r, er);
        hist[0][n_acc % HIST] = l;
        hist[1][n_acc % HIST] = r;
        n_acc++;
        @(negedge clk);
        in_valid = 1'b0;
        chk({"R2 valid ", req}, 32'(out_valid), 32'd1);
        if (kl) chk({"left ", req}, 32'(out_left), 32'(el));
        if (kr) chk({"right ", req}, 32'(out_right), 32'(er));
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk("R2 idle valid low", 32'(out_valid), 32'd0);
        end
    endtask

    task automatic burst(input int cnt, input string req, input bit gaps);
        for (int i = 0; i < cnt; i++) begin
            send(SW'($urandom), SW'($urandom), req);
            if (gaps && ($urandom % 4 == 0)) idle(1 + $urandom % 3);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        set_dly(0, 0);
        set_dly(1, 0);
        rst = 1'b1;
        in_valid = 1'b1;
        in_left = 16'h1234;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(out_valid), 32'd0);
        chk("R1 reset left", 32'(out_left), 32'd0);
        chk("R1 reset right", 32'(out_right), 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset valid", 32'(out_valid), 32'd0);

        // R4: zero delay pass-through
        burst(20, "R4 zero delay", 1'b1);

        // R5 / R10: independent small delays, idle gaps not counted
        set_dly(0, 1);
        set_dly(1, 7);
        burst(60, "R5 R10 short delays", 1'b1);

        // R3: right delay uses the high field (700 = hi 2, lo 188)
        set_dly(0, 5);
        set_dly(1, 700);
        burst(800, "R3 R5 long delay", 1'b0);

        // R5: longest exact delay wraps the ring
        set_dly(0, DEPTH - 1);
        set_dly(1, 3);
        burst(1100, "R5 depth-1 wrap", 1'b0);

        // R6 / R7: mute left, then right, then release
        ctrl_byte = 8'h40;
        burst(30, "R6 left muted", 1'b1);
        ctrl_byte = 8'h80;
        burst(30, "R6 right muted", 1'b1);
        ctrl_byte = 8'h00;
        burst(20, "R7 unmuted resume", 1'b1);

        // R8: bypass ignores delays; other mode codes behave the same
        ctrl_byte = 8'h03;
        burst(20, "R8 bypass", 1'b1);
        ctrl_byte = 8'hC3;
        burst(5, "R8 bypass muted", 1'b0);
        ctrl_byte = 8'h01;
        burst(20, "R8 mode 01 applies delay", 1'b1);
        ctrl_byte = 8'h3E;
        burst(20, "R8 mode 10 applies delay", 1'b1);
        ctrl_byte = 8'h00;

        // R9: delay changes on the next sample, buffer kept
        set_dly(0, 2);
        send(16'hAAAA, 16'h5555, "R9 change to 2");
        set_dly(0, 40);
        set_dly(1, 0);
        send(16'h0F0F, 16'hF0F0, "R9 change to 40");
        burst(10, "R9 after change", 1'b1);

        // random mix of settings
        for (int k = 0; k < 30; k++) begin
            set_dly(0, $urandom % DEPTH);
            set_dly(1, $urandom % DEPTH);
            ctrl_byte = 8'($urandom) & 8'hC3;
            burst(15, "R5 R6 R8 R10 random", 1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule